// File: doc/BRIEF.md
# Split Page-Size Translation Buffer

This block translates a 32-bit virtual address into a physical address every cycle. It keeps its mappings in two fully associative banks. One bank holds only 4 KiB page mappings. The other holds only large-page mappings, and each large entry is marked as either 2 MiB or 4 MiB. Because the page sizes are kept apart, every comparator in a bank works on a fixed slice of the address.

A lookup is combinational against the registered entry state. Both banks are searched at the same time, and the block returns hit, physical address, page size and a multi-hit flag. New mappings arrive through a fill port and take effect on the next clock edge. Two invalidation commands are provided. The first clears every entry. The second removes only the entries, in either bank, that would translate a given virtual address.

A fill goes to the lowest-numbered invalid slot of its bank. When the bank is full, the fill overwrites the slot named by that bank's round-robin pointer.

Top module: `tlb_split`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses with all outputs at zero.
- R2: A 4 KiB entry matches on address bits 31:12. On a hit, paddr_o is {stored frame bits 31:12, vaddr bits 11:0} and page_size_o is 0.
- R3: A 2 MiB large entry (size select 0) matches on bits 31:21. On a hit, paddr_o is {stored bits 31:21, vaddr bits 20:0} and page_size_o is 1.
- R4: A 4 MiB large entry (size select 1) matches on bits 31:22 only, and ignores bit 21 of both the stored and the presented address. On a hit, paddr_o is {stored bits 31:22, vaddr bits 21:0} and page_size_o is 2.
- R5: A lookup answers in the same cycle it is presented. A fill becomes visible from the cycle after its clock edge and not before.
- R6: When both banks hit, the large-page result is returned and multi_hit_o is 1. Otherwise multi_hit_o is 0.
- R7: A fill is written to the lowest-numbered invalid slot of the target bank.
- R8: A fill into a full bank replaces the slot named by that bank's round-robin pointer. The pointer starts at 0 after reset, advances by one with wrap-around on each such replacement, and does not move otherwise.
- R9: flush_all_i invalidates every entry in both banks. A fill presented in the same cycle is dropped.
- R10: A flush by address invalidates exactly those entries, in either bank, that would hit on flush_vaddr_i. All other entries survive.
- R11: On a miss, paddr_o, page_size_o and multi_hit_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_vaddr_i | input | 32 | Virtual address to translate |
| hit_o | output | 1 | Translation found |
| paddr_o | output | 32 | Translated physical address |
| page_size_o | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 4 MiB |
| multi_hit_o | output | 1 | Both banks matched |
| fill_en_i | input | 1 | Write a new mapping |
| fill_large_i | input | 1 | Target the large-page bank |
| fill_4m_i | input | 1 | Large entry covers 4 MiB (else 2 MiB) |
| fill_vaddr_i | input | 32 | Virtual address of the new mapping |
| fill_paddr_i | input | 32 | Physical address of the new mapping |
| flush_all_i | input | 1 | Invalidate every entry |
| flush_va_en_i | input | 1 | Invalidate entries matching flush_vaddr_i |
| flush_vaddr_i | input | 32 | Address for selective invalidation |

## Verification
The bench uses the default sizes of 16 small and 8 large entries. Addresses are drawn from a narrow pool of 16 large regions and 128 small pages, so both banks fill up early in the run. This keeps round-robin replacement, fills into holes left by selective flushes, and cross-bank multi-hits in play throughout. 2 MiB and 4 MiB entries share the same regions, which also exercises the bit-21 don't-care of 4 MiB matching against its neighbours.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;
  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_4M = 2'd2
  } page_size_e;
endpackage

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] slot_o
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign slot_o = free_found ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && !free_found) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_small_bank.sv
module tlb_small_bank #(
  parameter int unsigned N     = 16,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] look_va_i,
  output logic            hit_o,
  output logic [VA_W-1:0] pa_o,
  input  logic            flush_all_i,
  input  logic            flush_va_en_i,
  input  logic [VA_W-1:0] flush_va_i,
  input  logic            fill_en_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [VA_W-1:0] fill_pa_i
);
  localparam int unsigned PN_W  = VA_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     valid_q;
  logic [PN_W-1:0]  vpn_q [N];
  logic [PN_W-1:0]  ppn_q [N];
  logic [N-1:0]     look_hit;
  logic [N-1:0]     flush_hit;
  logic [PN_W-1:0]  ppn_sel;
  logic [IDX_W-1:0] slot;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign look_hit[g]  = valid_q[g] && (vpn_q[g] == look_va_i[VA_W-1:OFF_W]);
    assign flush_hit[g] = flush_va_en_i && valid_q[g] &&
                          (vpn_q[g] == flush_va_i[VA_W-1:OFF_W]);
  end

  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (look_hit[i]) ppn_sel = ppn_sel | ppn_q[i];
    end
  end

  assign hit_o = |look_hit;
  assign pa_o  = hit_o ? {ppn_sel, look_va_i[OFF_W-1:0]} : '0;

  tlb_slot_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .alloc_i (fill_en_i),
    .slot_o  (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_hit[i]) valid_q[i] <= 1'b0;
        if (fill_en_i && (slot == IDX_W'(i))) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      vpn_q[slot] <= fill_va_i[VA_W-1:OFF_W];
      ppn_q[slot] <= fill_pa_i[VA_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/tlb_large_bank.sv
module tlb_large_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] look_va_i,
  output logic            hit_o,
  output logic            big_o,
  output logic [VA_W-1:0] pa_o,
  input  logic            flush_all_i,
  input  logic            flush_va_en_i,
  input  logic [VA_W-1:0] flush_va_i,
  input  logic            fill_en_i,
  input  logic            fill_big_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [VA_W-1:0] fill_pa_i
);
  localparam int unsigned PN_W  = VA_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     valid_q;
  logic [N-1:0]     big_q;
  logic [PN_W-1:0]  vpn_q [N];
  logic [PN_W-1:0]  ppn_q [N];
  logic [N-1:0]     look_hit;
  logic [N-1:0]     flush_hit;
  logic [PN_W-1:0]  ppn_sel;
  logic             big_sel;
  logic [IDX_W-1:0] slot;

  function automatic logic tag_eq(logic big, logic [PN_W-1:0] vpn, logic [VA_W-1:0] va);
    if (big) return vpn[PN_W-1:1] == va[VA_W-1:OFF_W+1];
    return vpn == va[VA_W-1:OFF_W];
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign look_hit[g]  = valid_q[g] && tag_eq(big_q[g], vpn_q[g], look_va_i);
    assign flush_hit[g] = flush_va_en_i && valid_q[g] && tag_eq(big_q[g], vpn_q[g], flush_va_i);
  end

  always_comb begin
    ppn_sel = '0;
    big_sel = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (look_hit[i]) begin
        ppn_sel = ppn_sel | ppn_q[i];
        big_sel = big_sel | big_q[i];
      end
    end
  end

  assign hit_o = |look_hit;
  assign big_o = hit_o && big_sel;

  always_comb begin
    if (!hit_o)      pa_o = '0;
    else if (big_sel) pa_o = {ppn_sel[PN_W-1:1], look_va_i[OFF_W:0]};
    else             pa_o = {ppn_sel, look_va_i[OFF_W-1:0]};
  end

  tlb_slot_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .alloc_i (fill_en_i),
    .slot_o  (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_hit[i]) valid_q[i] <= 1'b0;
        if (fill_en_i && (slot == IDX_W'(i))) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      vpn_q[slot] <= fill_va_i[VA_W-1:OFF_W];
      ppn_q[slot] <= fill_pa_i[VA_W-1:OFF_W];
      big_q[slot] <= fill_big_i;
    end
  end
endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlb_split_pkg::*;
#(
  parameter int unsigned N_SMALL   = 16,
  parameter int unsigned N_LARGE   = 8,
  parameter int unsigned VA_W      = 32,
  parameter int unsigned SMALL_OFF = 12,
  parameter int unsigned LARGE_OFF = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] lookup_vaddr_i,
  output logic            hit_o,
  output logic [VA_W-1:0] paddr_o,
  output logic [1:0]      page_size_o,
  output logic            multi_hit_o,
  input  logic            fill_en_i,
  input  logic            fill_large_i,
  input  logic            fill_4m_i,
  input  logic [VA_W-1:0] fill_vaddr_i,
  input  logic [VA_W-1:0] fill_paddr_i,
  input  logic            flush_all_i,
  input  logic            flush_va_en_i,
  input  logic [VA_W-1:0] flush_vaddr_i
);
  logic            s_fill, l_fill;
  logic            s_hit, l_hit, l_big;
  logic [VA_W-1:0] s_pa, l_pa;
  page_size_e      size;

  assign s_fill = fill_en_i && !flush_all_i && !fill_large_i;
  assign l_fill = fill_en_i && !flush_all_i &&  fill_large_i;

  tlb_small_bank #(.N(N_SMALL), .VA_W(VA_W), .OFF_W(SMALL_OFF)) u_small (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .look_va_i     (lookup_vaddr_i),
    .hit_o         (s_hit),
    .pa_o          (s_pa),
    .flush_all_i   (flush_all_i),
    .flush_va_en_i (flush_va_en_i),
    .flush_va_i    (flush_vaddr_i),
    .fill_en_i     (s_fill),
    .fill_va_i     (fill_vaddr_i),
    .fill_pa_i     (fill_paddr_i)
  );

  tlb_large_bank #(.N(N_LARGE), .VA_W(VA_W), .OFF_W(LARGE_OFF)) u_large (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .look_va_i     (lookup_vaddr_i),
    .hit_o         (l_hit),
    .big_o         (l_big),
    .pa_o          (l_pa),
    .flush_all_i   (flush_all_i),
    .flush_va_en_i (flush_va_en_i),
    .flush_va_i    (flush_vaddr_i),
    .fill_en_i     (l_fill),
    .fill_big_i    (fill_4m_i),
    .fill_va_i     (fill_vaddr_i),
    .fill_pa_i     (fill_paddr_i)
  );

  always_comb begin
    if (l_hit)      size = l_big ? PG_4M : PG_2M;
    else            size = PG_4K;
  end

  assign hit_o       = s_hit || l_hit;
  assign paddr_o     = l_hit ? l_pa : s_pa;
  assign page_size_o = size;
  assign multi_hit_o = s_hit && l_hit;
endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [VA_W-1:0] lookup_vaddr_i,
  input logic            hit_o,
  input logic [VA_W-1:0] paddr_o,
  input logic [1:0]      page_size_o,
  input logic            multi_hit_o,
  input logic            fill_en_i,
  input logic            flush_all_i,
  input logic            flush_va_en_i,
  input logic [VA_W-1:0] flush_vaddr_i
);
  assert_small_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && page_size_o == 2'd0) |-> paddr_o[11:0] == lookup_vaddr_i[11:0]);

  assert_2m_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && page_size_o == 2'd1) |-> paddr_o[20:0] == lookup_vaddr_i[20:0]);

  assert_4m_offset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && page_size_o == 2'd2) |-> paddr_o[21:0] == lookup_vaddr_i[21:0]);

  assert_multi_large_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> (hit_o && page_size_o != 2'd0));

  assert_flush_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> !hit_o);

  assert_flush_va_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_va_en_i && !flush_all_i && !fill_en_i) |=>
      !(hit_o && lookup_vaddr_i == $past(flush_vaddr_i)));

  assert_miss_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == '0 && page_size_o == 2'd0 && !multi_hit_o));
endmodule

bind tlb_split tlb_split_chk #(.VA_W(VA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_vaddr_i (lookup_vaddr_i),
  .hit_o          (hit_o),
  .paddr_o        (paddr_o),
  .page_size_o    (page_size_o),
  .multi_hit_o    (multi_hit_o),
  .fill_en_i      (fill_en_i),
  .flush_all_i    (flush_all_i),
  .flush_va_en_i  (flush_va_en_i),
  .flush_vaddr_i  (flush_vaddr_i)
);

// File: tb/tlb_split_bench.sv
`timescale 1ns/1ps
module tlb_split_bench;
  localparam int NS = 16;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lva = '0;
  logic        hit, multi;
  logic [31:0] pa;
  logic [1:0]  psz;
  logic        fen = 1'b0, flarge = 1'b0, f4m = 1'b0;
  logic [31:0] fva = '0, fpa = '0;
  logic        fall = 1'b0, fven = 1'b0;
  logic [31:0] fvva = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tlb_split u_tlb_split (
    .clk_i(clk), .rst_ni(rst_n), .lookup_vaddr_i(lva), .hit_o(hit), .paddr_o(pa),
    .page_size_o(psz), .multi_hit_o(multi), .fill_en_i(fen), .fill_large_i(flarge),
    .fill_4m_i(f4m), .fill_vaddr_i(fva), .fill_paddr_i(fpa), .flush_all_i(fall),
    .flush_va_en_i(fven), .flush_vaddr_i(fvva)
  );

  // reference model
  bit          s_v [NS];
  logic [19:0] s_vpn [NS], s_ppn [NS];
  bit          l_v [NL], l_big [NL];
  logic [10:0] l_vpn [NL], l_ppn [NL];
  int          rr_s = 0, rr_l = 0;

  function automatic bit l_match(int i, logic [31:0] va);
    if (!l_v[i]) return 1'b0;
    if (l_big[i]) return l_vpn[i][10:1] == va[31:22];
    return l_vpn[i] == va[31:21];
  endfunction

  function automatic bit s_any(logic [31:0] va);
    for (int i = 0; i < NS; i++) if (s_v[i] && s_vpn[i] == va[31:12]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit l_any(logic [31:0] va);
    for (int i = 0; i < NL; i++) if (l_match(i, va)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_look(input logic [31:0] va, output bit h, output logic [31:0] p,
                            output logic [1:0] sz, output bit m);
    bit sh, lh;
    sh = 0; lh = 0; p = '0; sz = 2'd0;
    for (int i = 0; i < NS; i++)
      if (s_v[i] && s_vpn[i] == va[31:12]) begin sh = 1; p = {s_ppn[i], va[11:0]}; end
    for (int i = 0; i < NL; i++)
      if (l_match(i, va)) begin
        lh = 1;
        if (l_big[i]) begin p = {l_ppn[i][10:1], va[21:0]}; sz = 2'd2; end
        else          begin p = {l_ppn[i], va[20:0]};       sz = 2'd1; end
      end
    h = sh || lh;
    m = sh && lh;
  endtask

  task automatic model_update();
    int slot;
    bit full;
    if (fall) begin
      for (int i = 0; i < NS; i++) s_v[i] = 0;
      for (int i = 0; i < NL; i++) l_v[i] = 0;
      return;
    end
    slot = -1;
    if (fen && !flarge) begin
      for (int i = NS - 1; i >= 0; i--) if (!s_v[i]) slot = i;
      full = (slot < 0);
      if (full) begin slot = rr_s; rr_s = (rr_s + 1) % NS; end
    end else if (fen) begin
      for (int i = NL - 1; i >= 0; i--) if (!l_v[i]) slot = i;
      full = (slot < 0);
      if (full) begin slot = rr_l; rr_l = (rr_l + 1) % NL; end
    end
    if (fven) begin
      for (int i = 0; i < NS; i++) if (s_v[i] && s_vpn[i] == fvva[31:12]) s_v[i] = 0;
      for (int i = 0; i < NL; i++) if (l_match(i, fvva)) l_v[i] = 0;
    end
    if (fen && !flarge) begin
      s_v[slot] = 1; s_vpn[slot] = fva[31:12]; s_ppn[slot] = fpa[31:12];
    end else if (fen) begin
      l_v[slot] = 1; l_big[slot] = f4m; l_vpn[slot] = fva[31:21]; l_ppn[slot] = fpa[31:21];
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, compare lookup against model, clock, update model
  task automatic step(string req, logic [31:0] va, bit fe, bit fl, bit fb,
                      logic [31:0] fv, logic [31:0] fp, bit fa, bit fve, logic [31:0] ffv);
    bit h, m;
    logic [31:0] p;
    logic [1:0] sz;
    @(negedge clk);
    lva = va; fen = fe; flarge = fl; f4m = fb; fva = fv; fpa = fp;
    fall = fa; fven = fve; fvva = ffv;
    #1;
    model_look(va, h, p, sz, m);
    check({req, " hit"},   {31'd0, hit},   {31'd0, h});
    check({req, " paddr"}, pa,             p);
    check({req, " size"},  {30'd0, psz},   {30'd0, sz});
    check({req, " multi"}, {31'd0, multi}, {31'd0, m});
    @(posedge clk);
    model_update();
  endtask

  task automatic look(string req, logic [31:0] va, bit eh, logic [31:0] ep,
                      logic [1:0] es, bit em);
    @(negedge clk);
    lva = va; fen = 0; fall = 0; fven = 0;
    #1;
    check({req, " hit"},   {31'd0, hit},   {31'd0, eh});
    check({req, " paddr"}, pa,             ep);
    check({req, " size"},  {30'd0, psz},   {30'd0, es});
    check({req, " multi"}, {31'd0, multi}, {31'd0, em});
    @(posedge clk);
  endtask

  task automatic fill(string req, logic [31:0] va, logic [31:0] p, bit lg, bit b4);
    step(req, va, 1, lg, b4, va, p, 0, 0, '0);
  endtask

  task automatic flush_va(string req, logic [31:0] va);
    step(req, va, 0, 0, 0, '0, '0, 0, 1, va);
  endtask

  function automatic logic [31:0] rand_va();
    return {7'd0, 4'($urandom_range(0, 15)), 6'd0, 3'($urandom_range(0, 7)), 12'($urandom)};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1a));
    for (int i = 0; i < NS; i++) s_v[i] = 0;
    for (int i = 0; i < NL; i++) begin l_v[i] = 0; l_big[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look("R1 R11 reset", 32'h0040_1234, 0, 32'h0, 2'd0, 0);
    // R5: not visible in its own fill cycle
    fill("R5 fill 4k", 32'h0040_3000, 32'h1234_5000, 0, 0);
    look("R2 R5 4k hit", 32'h0040_3abc, 1, 32'h1234_5abc, 2'd0, 0);
    fill("R3 fill 2m", 32'h0060_0000, 32'h8ac0_0000, 1, 0);
    look("R3 2m hit", 32'h006a_bcde, 1, 32'h8aca_bcde, 2'd1, 0);
    fill("R4 fill 4m", 32'h0100_0000, 32'h4020_0000, 1, 1);
    look("R4 4m hit upper half", 32'h013f_ffff, 1, 32'h403f_ffff, 2'd2, 0);
    look("R4 4m hit lower half", 32'h0100_0010, 1, 32'h4000_0010, 2'd2, 0);
    fill("R6 fill 2m overlap", 32'h0040_0000, 32'h2000_0000, 1, 0);
    look("R6 multi hit", 32'h0040_3abc, 1, 32'h2000_3abc, 2'd1, 1);
    flush_va("R10 flush va", 32'h0040_3000);
    look("R10 flushed miss", 32'h0040_3abc, 0, 32'h0, 2'd0, 0);
    look("R10 other survives", 32'h006a_bcde, 1, 32'h8aca_bcde, 2'd1, 0);
    step("R9 flush all + fill", 32'h0, 1, 0, 0, 32'h0080_0000, 32'h0, 1, 0, '0);
    look("R9 4m gone", 32'h013f_ffff, 0, 32'h0, 2'd0, 0);
    look("R9 fill dropped", 32'h0080_0000, 0, 32'h0, 2'd0, 0);

    // R7 / R8: fill small bank, then overflow
    for (int i = 0; i < NS; i++)
      fill("R7 fill", 32'h1000_0000 + (i << 12), 32'h2000_0000 + (i << 12), 0, 0);
    fill("R8 overflow", 32'h1010_0000, 32'h3010_0000, 0, 0);
    look("R8 slot0 replaced", 32'h1000_0000, 0, 32'h0, 2'd0, 0);
    look("R8 slot1 kept", 32'h1000_1004, 1, 32'h2000_1004, 2'd0, 0);
    look("R8 new entry", 32'h1010_0008, 1, 32'h3010_0008, 2'd0, 0);
    flush_va("R7 hole", 32'h1000_5000);
    fill("R7 fill hole", 32'h1020_0000, 32'h3020_0000, 0, 0);
    fill("R8 next rr", 32'h1030_0000, 32'h3030_0000, 0, 0);
    look("R8 slot1 replaced", 32'h1000_1000, 0, 32'h0, 2'd0, 0);
    look("R7 slot2 kept", 32'h1000_2000, 1, 32'h2000_2000, 2'd0, 0);
    look("R7 hole entry", 32'h1020_0000, 1, 32'h3020_0000, 2'd0, 0);
    step("R9 clear", 32'h0, 0, 0, 0, '0, '0, 1, 0, '0);

    // constrained random against model
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [31:0] va, fv, fp;
      bit lg, b4, ok;
      va = rand_va();
      op = $urandom_range(0, 99);
      if (op < 40) begin
        fv = rand_va();
        fp = $urandom;
        lg = ($urandom_range(0, 2) == 0);
        b4 = $urandom_range(0, 1);
        if (!lg) ok = !s_any(fv);
        else if (b4) ok = !l_any({fv[31:22], 22'd0}) && !l_any({fv[31:22], 22'h20_0000});
        else ok = !l_any(fv) && !l_any({fv[31:22], 22'd0});
        if (ok && !lg) step("R5 R7 R8 rnd fill", va, 1, 0, 0, fv, fp, 0, 0, '0);
        else if (ok)   step("R3 R4 R6 rnd fill", va, 1, 1, b4, fv, fp, 0, 0, '0);
        else           step("R2 rnd look", va, 0, 0, 0, '0, '0, 0, 0, '0);
      end else if (op < 48) begin
        step("R10 rnd flush", va, 0, 0, 0, '0, '0, 0, 1, rand_va());
      end else if (op < 49) begin
        step("R9 rnd flush all", va, 0, 0, 0, '0, '0, 1, 0, '0);
      end else begin
        step("R2 R3 R4 R6 rnd look", va, 0, 0, 0, '0, '0, 0, 0, '0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule